// File: doc/BRIEF.md
# Switchable Domain Power Sequencer

This always-on controller takes one switchable power domain through shutdown and wake-up. A sleep request makes it clamp the domain's outputs, pulse retention save, wait one settling cycle and open all power-switch segments at once. A wake request closes the switch segments one after another with a programmable gap between them, which limits inrush current. It then waits for the acknowledge from the far end of the switch string and holds the non-retained logic in reset for a fixed time. After that it pulses retention restore, waits one settling cycle and only then releases the clamps and reports the domain ready.

If the acknowledge does not arrive within a programmable number of clock edges, the sequencer enters a sticky error state. In that state the switches are open, the clamps stay on and the non-retained reset stays asserted until the block's own reset. A sleep request that arrives during a wake sequence is held until the domain is ready. A wake request that arrives during a shutdown is held until the domain is fully off. The block leaves reset in the powered-off state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is in the off state: iso_en_o=1, sw_en_o all zero, nret_rst_o=1, and save_o, restore_o, ready_o, busy_o and err_o all 0.
- R2: A wake_req_i sampled high while off enables bit 0 of sw_en_o in the next cycle. Bit k (LSB first) comes on G cycles after bit k-1, where G is seg_gap_i and a value of 0 is treated as 1. Only one new bit comes on per step. busy_o is 1 and iso_en_o stays 1 throughout.
- R3: Once every segment is on, a sw_ack_i sampled high on any of the next T clock edges is accepted. T is ack_timeout_i, and a value of 0 is treated as 1.
- R4: After the acknowledge edge, nret_rst_o stays high for exactly RST_CYC cycles and falls before restore. restore_o then stays high for exactly PULSE_CYC cycles.
- R5: After restore there is one cycle with iso_en_o=1 and both pulses low. Then iso_en_o falls and ready_o rises in the same cycle, with every segment on and nret_rst_o low.
- R6: A sleep_req_i sampled while ready starts shutdown. In the first cycle iso_en_o=1 and ready_o=0. save_o is then high for PULSE_CYC cycles with every segment on. One settling cycle follows, then all segments turn off together and nret_rst_o rises. No segment turns off unless isolation was already on in the previous cycle.
- R7: If no acknowledge is seen on those T edges, err_o rises T cycles after the last segment came on. It stays high, with iso_en_o=1, sw_en_o=0 and nret_rst_o=1, whatever requests arrive, until rst_ni clears it.
- R8: A sleep request sampled during a wake sequence is deferred. ready_o is high for exactly one cycle, and then shutdown begins.
- R9: A wake request sampled during a shutdown is deferred. The domain spends one cycle fully off, and then segment 0 turns on.
- R10: sleep_req_i while off and wake_req_i while ready have no effect on any output and leave no pending request behind.
- R11: save_o and restore_o are only ever high while isolation is on and every segment is on. restore_o is only high with nret_rst_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to power the domain down |
| wake_req_i | input | 1 | Request to power the domain up |
| sw_ack_i | input | 1 | Acknowledge from the last switch segment |
| seg_gap_i | input | 8 | Cycles between successive segment enables (0 acts as 1) |
| ack_timeout_i | input | TO_W | Clock edges allowed for the acknowledge (0 acts as 1) |
| iso_en_o | output | 1 | Clamp enable for the domain's outputs |
| save_o | output | 1 | Retention save pulse |
| restore_o | output | 1 | Retention restore pulse |
| sw_en_o | output | NSEG | Per-segment power-switch enable |
| nret_rst_o | output | 1 | Reset for non-retained registers |
| ready_o | output | 1 | Domain powered, restored and unclamped |
| busy_o | output | 1 | A sequence is in progress |
| err_o | output | 1 | Sticky acknowledge timeout |

## Verification
The wake sequence runs with gaps of 0, 1, 2, 3, 5 and 255. Gap 0 and gap 1 should give the same one-cycle stagger, and the gap of 255 exposes any truncation of the gap count. The acknowledge arrives at the first edge, partway into the window, exactly on the last allowed edge, and one edge too late, so an off-by-one in the timeout window cannot hide in either direction. Separate runs insert a sleep request partway through waking and a wake request partway through shutdown, and send requests that should be ignored. These runs tell deferral apart from both dropping a request and acting on it early.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_OFF,
    ST_SWON,
    ST_ACKW,
    ST_RST,
    ST_RESTORE,
    ST_RSETTLE,
    ST_ON,
    ST_ISO,
    ST_SAVE,
    ST_SSETTLE,
    ST_ERR
  } pseq_state_e;
endpackage

// File: rtl/pwr_seq_cnt.sv
module pwr_seq_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_chain.sv
module pwr_seq_chain #(
  parameter int NSEG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic            step_i,
  output logic [NSEG-1:0] seg_o,
  output logic            last_o
);
  logic [NSEG-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seg_q <= '0;
    else if (clr_i)    seg_q <= '0;
    else if (start_i)  seg_q <= NSEG'(1);
    else if (step_i)   seg_q <= {seg_q[NSEG-2:0], 1'b1};
  end

  assign seg_o  = seg_q;
  assign last_o = seg_q[NSEG-2];  // next step fills the string

  // R2
  seg_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_q != $past(seg_q)) && (seg_q != '0))
      |-> ($countones(seg_q) == $countones($past(seg_q)) + 1));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NSEG      = 4,
  parameter int PULSE_CYC = 2,
  parameter int RST_CYC   = 4,
  parameter int TO_W      = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic            wake_req_i,
  input  logic            sw_ack_i,
  input  logic [7:0]      seg_gap_i,
  input  logic [TO_W-1:0] ack_timeout_i,
  output logic            iso_en_o,
  output logic            save_o,
  output logic            restore_o,
  output logic [NSEG-1:0] sw_en_o,
  output logic            nret_rst_o,
  output logic            ready_o,
  output logic            busy_o,
  output logic            err_o
);
  localparam int CW = (TO_W > 8) ? TO_W : 8;

  pseq_state_e state_q, state_d;
  logic pend_sleep_q, pend_sleep_d, pend_wake_q, pend_wake_d;
  logic cnt_load, cnt_zero;
  logic [CW-1:0] cnt_val, gap_ld, to_ld;
  logic ch_clr, ch_start, ch_step, ch_last;
  logic waking, shutting;

  assign gap_ld = (seg_gap_i == '0) ? '0 : CW'(seg_gap_i) - 1'b1;
  assign to_ld  = (ack_timeout_i == '0) ? '0 : CW'(ack_timeout_i) - 1'b1;

  pwr_seq_cnt #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  pwr_seq_chain #(.NSEG(NSEG)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ch_clr),
    .start_i (ch_start),
    .step_i  (ch_step),
    .seg_o   (sw_en_o),
    .last_o  (ch_last)
  );

  assign waking   = state_q inside {ST_SWON, ST_ACKW, ST_RST, ST_RESTORE, ST_RSETTLE};
  assign shutting = state_q inside {ST_ISO, ST_SAVE, ST_SSETTLE};

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    ch_clr   = 1'b0;
    ch_start = 1'b0;
    ch_step  = 1'b0;
    unique case (state_q)
      ST_OFF: if (wake_req_i || pend_wake_q) begin
        state_d  = ST_SWON;
        ch_start = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = gap_ld;
      end
      ST_SWON: if (cnt_zero) begin
        ch_step  = 1'b1;
        cnt_load = 1'b1;
        if (ch_last) begin
          state_d = ST_ACKW;
          cnt_val = to_ld;
        end else begin
          cnt_val = gap_ld;
        end
      end
      ST_ACKW: begin
        if (sw_ack_i) begin
          state_d  = ST_RST;
          cnt_load = 1'b1;
          cnt_val  = CW'(RST_CYC - 1);
        end else if (cnt_zero) begin
          state_d = ST_ERR;
          ch_clr  = 1'b1;
        end
      end
      ST_RST: if (cnt_zero) begin
        state_d  = ST_RESTORE;
        cnt_load = 1'b1;
        cnt_val  = CW'(PULSE_CYC - 1);
      end
      ST_RESTORE: if (cnt_zero) state_d = ST_RSETTLE;
      ST_RSETTLE: state_d = ST_ON;
      ST_ON: if (sleep_req_i || pend_sleep_q) state_d = ST_ISO;
      ST_ISO: begin
        state_d  = ST_SAVE;
        cnt_load = 1'b1;
        cnt_val  = CW'(PULSE_CYC - 1);
      end
      ST_SAVE: if (cnt_zero) state_d = ST_SSETTLE;
      ST_SSETTLE: begin
        state_d = ST_OFF;
        ch_clr  = 1'b1;
      end
      ST_ERR: state_d = ST_ERR;
      default: state_d = ST_OFF;
    endcase
  end

  always_comb begin
    pend_sleep_d = pend_sleep_q;
    pend_wake_d  = pend_wake_q;
    if (waking && sleep_req_i)                  pend_sleep_d = 1'b1;
    if (state_q == ST_ON || state_q == ST_ERR)  pend_sleep_d = 1'b0;
    if (shutting && wake_req_i)                 pend_wake_d  = 1'b1;
    if (state_q == ST_OFF || state_q == ST_ERR) pend_wake_d  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_OFF;
      pend_sleep_q <= 1'b0;
      pend_wake_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      pend_sleep_q <= pend_sleep_d;
      pend_wake_q  <= pend_wake_d;
    end
  end

  assign iso_en_o   = (state_q != ST_ON);
  assign save_o     = (state_q == ST_SAVE);
  assign restore_o  = (state_q == ST_RESTORE);
  assign nret_rst_o = state_q inside {ST_OFF, ST_SWON, ST_ACKW, ST_RST, ST_ERR};
  assign ready_o    = (state_q == ST_ON);
  assign err_o      = (state_q == ST_ERR);
  assign busy_o     = waking || shutting;

  // R6
  iso_before_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sw_en_o) < $countones($past(sw_en_o))) |-> ($past(iso_en_o) && iso_en_o));

  // R2
  iso_before_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sw_en_o) && !(|$past(sw_en_o))) |-> (iso_en_o && $past(iso_en_o)));

  // R11
  save_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> (iso_en_o && (&sw_en_o)));

  // R11
  restore_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (iso_en_o && (&sw_en_o) && !nret_rst_o));

  // R5
  ready_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((&sw_en_o) && !nret_rst_o && !save_o && !restore_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_o) |-> (err_o && iso_en_o && (sw_en_o == '0) && nret_rst_o));
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 4;
  localparam int PULSE = 2;
  localparam int RSTC  = 4;
  localparam int TO_W  = 16;
  localparam int NVEC  = 7;
  // {gap, timeout, ack delay after last segment}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1,   16'd4, 16'd0},
    {8'd3,   16'd8, 16'd2},
    {8'd0,   16'd5, 16'd4},
    {8'd255, 16'd2, 16'd1},
    {8'd2,   16'd3, 16'd3},
    {8'd5,   16'd1, 16'd0},
    {8'd1,   16'd1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, sw_ack = 1'b0;
  logic [7:0] seg_gap = 8'd1;
  logic [TO_W-1:0] ack_to = 16'd4;
  logic iso, save, restore, nret, ready, busy, err;
  logic [NSEG-1:0] sw_en;

  int checks = 0, failures = 0;
  int seg_bad, iso_bad, f_nret, f_rest, rest_len, f_ready, f_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.NSEG(NSEG), .PULSE_CYC(PULSE), .RST_CYC(RSTC), .TO_W(TO_W)) u_pwr_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .sw_ack_i(sw_ack), .seg_gap_i(seg_gap), .ack_timeout_i(ack_to),
    .iso_en_o(iso), .save_o(save), .restore_o(restore), .sw_en_o(sw_en),
    .nret_rst_o(nret), .ready_o(ready), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_off();
    return iso && sw_en == '0 && nret && !save && !restore && !ready && !busy && !err;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; sw_ack = 1'b0;
    @(negedge clk);
    chk(is_off(), "R1 in reset", int'(sw_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(is_off(), "R1 after reset", int'(sw_en), 0);
  endtask

  task automatic run_wake(input int gap, input int to, input int d, input bit exp_err, input int sleep_at);
    int g, t, last, x;
    g = (gap == 0) ? 1 : gap;
    t = (to == 0) ? 1 : to;
    last = (NSEG - 1) * g;
    seg_gap = 8'(gap); ack_to = TO_W'(to);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    seg_bad = 0; iso_bad = 0; f_nret = -1; f_rest = -1; rest_len = 0; f_ready = -1; f_err = -1;
    for (int idx = 0; idx < 3000; idx++) begin
      if (idx <= last && $countones(sw_en) != idx / g + 1) seg_bad++;
      if (idx <= last && !busy) seg_bad++;
      if (!ready && !iso) iso_bad++;
      if (!nret && f_nret < 0) f_nret = idx;
      if (restore) begin
        if (f_rest < 0) f_rest = idx;
        rest_len++;
      end
      if (err && f_err < 0) f_err = idx;
      if (ready) begin f_ready = idx; break; end
      if (err) break;
      if (!exp_err && idx == last + d) sw_ack = 1'b1;
      sleep_req = (idx == sleep_at);
      @(negedge clk);
    end
    sleep_req = 1'b0;
    chk(seg_bad == 0, "R2 segment stagger", seg_bad, 0);
    chk(iso_bad == 0, "R2 isolation held", iso_bad, 0);
    if (exp_err) begin
      chk(f_err == last + t, "R7 timeout cycle", f_err, last + t);
    end else begin
      x = last + d + 1;
      chk(f_err < 0 && f_ready >= 0, "R3 ack accepted", f_err, -1);
      chk(f_nret == x + RSTC, "R4 nret reset length", f_nret, x + RSTC);
      chk(f_rest == x + RSTC && rest_len == PULSE, "R4 restore pulse", rest_len, PULSE);
      chk(f_ready == x + RSTC + PULSE + 1, "R5 ready cycle", f_ready, x + RSTC + PULSE + 1);
    end
  endtask

  task automatic run_sleep(input int wake_at);
    int f_save, save_len, f_off, bad;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    f_save = -1; save_len = 0; f_off = -1; bad = 0;
    for (int idx = 0; idx <= PULSE + 2; idx++) begin
      if (idx == 0 && (ready || !iso || save)) bad++;
      if (save) begin
        if (f_save < 0) f_save = idx;
        save_len++;
        if (sw_en != '1 || !iso) bad++;
      end
      if (sw_en == '0 && f_off < 0) f_off = idx;
      if (idx == PULSE + 2 && !nret) bad++;
      wake_req = (idx == wake_at);
      @(negedge clk);
    end
    wake_req = 1'b0;
    sw_ack = 1'b0;
    chk(f_save == 1 && save_len == PULSE, "R6 save pulse", save_len, PULSE);
    chk(f_off == PULSE + 2, "R6 switch-off cycle", f_off, PULSE + 2);
    chk(bad == 0, "R6 shutdown outputs", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      int gap, to, d;
      bit e;
      gap = int'(VEC[v][39:32]);
      to  = int'(VEC[v][31:16]);
      d   = int'(VEC[v][15:0]);
      e   = (d + 1 > ((to == 0) ? 1 : to));
      do_reset();
      run_wake(gap, to, d, e, -1);
      if (e) begin
        // R7 sticky against requests
        wake_req = 1'b1; sleep_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0; sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(err && iso && sw_en == '0 && nret && !busy, "R7 error sticky", int'(err), 1);
      end else begin
        run_sleep(-1);
      end
    end

    // R8: sleep during wake is deferred
    do_reset();
    run_wake(1, 4, 0, 1'b0, 1);
    @(negedge clk);
    chk(!ready && iso && !save, "R8 deferred sleep starts", int'(ready), 0);
    repeat (PULSE + 2) @(negedge clk);
    chk(sw_en == '0 && !busy, "R8 deferred sleep completes", int'(sw_en), 0);

    // R9: wake during shutdown is deferred
    do_reset();
    run_wake(2, 4, 1, 1'b0, -1);
    run_sleep(1);
    chk(sw_en == NSEG'(1) && busy && iso, "R9 deferred wake starts", int'(sw_en), 1);

    // R10: ignored requests
    do_reset();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(is_off(), "R10 sleep while off", int'(busy), 0);
    run_wake(1, 4, 0, 1'b0, -1);
    repeat (3) @(negedge clk);
    chk(ready && !iso, "R10 no pending sleep", int'(ready), 1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready && !busy && sw_en == '1 && !nret, "R10 wake while ready", int'(ready), 1);
    run_sleep(-1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule